// File: doc/BRIEF.md
# Clock-generator serial control register bank

This block is the two-wire serial slave that holds the control bytes of a clock generator. A system controller addresses it with a block-write or a block-read transaction. It decodes one fixed 7-bit device address. In a write, it accepts a command byte and a byte count, neither of which it acts on, and then stores each data byte at the next position of a byte index that starts at zero. In a read, it sends the number of defined bytes first and then the bytes in ascending order. The serial clock is synchronized and glitch-filtered inside the block. The data line is open drain: the block only ever pulls it low, through an output enable.

Several read-back bits are not storage. They show the live levels of the CPU-halt pin, the PCI-halt pin and the frequency-select pins. One bit shows the logical AND of the PCI-halt pin and a register bit, and that AND also goes out as the effective PCI-run signal. Divider values for the synthesizer are staged in two bytes and reach the working divider outputs only while a load-gate bit is set. The bank runs from its own clock and is cleared only by the power-on reset, so its contents survive any power-down state of the rest of the chip.

Top module: `clkgen_smb_regs`

## Requirements
- R1: The block acknowledges only the write address 0xD2 and the read address 0xD3 (7-bit address 0x69). For any other address it leaves the data line released for the whole transaction and changes no register.
- R2: In a write, the block acknowledges the command byte and the byte-count byte that follow the address. Their values have no effect on where data lands or on what is stored.
- R3: Data bytes of a write are stored at index 0, 1, 2, ... in order, and each one is acknowledged. Bytes sent past index 9 are acknowledged and discarded. Write masks per byte: byte 0 0xE8, byte 1 0x3F, byte 2 0x7F, byte 3 0xFF, byte 4 0xBF, byte 5 0xFF, byte 6 0x00, bytes 7 to 9 0xFF. Bits outside a mask keep their value.
- R4: Byte 0 reads back as {stored bits 7:5, CPU-halt pin in bit 4, bit 3 per R5, select pins 2:0 in bits 2:0}. Byte 1 reads back with the multiplier pin in bit 7 and a 0 in bit 6.
- R5: Byte 0 bit 3 reads back as the AND of the PCI-halt pin and the stored bit 3. The output `pci_run` carries the same AND.
- R6: Byte 6 always reads 0x03. A write to it is acknowledged and leaves it unchanged.
- R7: After reset the stored bytes are 0x08, 0x07, 0x7F, 0xC7, 0x3F, 0x40, (0x03), 0x00, 0x00 and 0x00 for bytes 0 to 9, and both working divider outputs are 0.
- R8: While byte 9 bit 0 is 1, `div_n` follows byte 8 and `div_r` follows byte 9 bits 7:1. While that bit is 0, both outputs hold their value.
- R9: A block read returns the count 10 first and then bytes 0 upward. Any byte after byte 9 reads 0x00. A master NACK ends the sending.
- R10: A STOP or a repeated START returns the slave to address reception with the byte index at 0, so the next data byte lands at byte 0 and the next read begins with the count.
- R11: The bits that no mask covers read as 0: byte 1 bit 6, byte 2 bit 7 and byte 4 bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock, also used to sample the serial lines |
| rst_n | input | 1 | Active-low power-on reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| cpu_halt_n | input | 1 | CPU clock halt pin level, shown in byte 0 bit 4 |
| pci_halt_n | input | 1 | PCI clock halt pin level, ANDed into byte 0 bit 3 |
| fsel | input | 3 | Frequency-select pin levels, shown in byte 0 bits 2:0 |
| cur_mult | input | 1 | Output-current multiplier pin, shown in byte 1 bit 7 |
| cpu_ctrl | output | 8 | Stored byte 0 |
| cpu_gate | output | 8 | Stored byte 1 |
| pci_en | output | 8 | Stored byte 2 |
| aux_en | output | 8 | Stored byte 3 |
| mid_en | output | 8 | Stored byte 4 |
| misc_ctrl | output | 8 | Stored byte 5 |
| pci_run | output | 1 | PCI-halt pin AND stored byte 0 bit 3 |
| div_n | output | 8 | Working N divider value |
| div_r | output | 7 | Working R divider value |

## Verification
The hardest situation to reach is the one where the byte index is reset in the middle of a transaction. A repeated START that arrives after some data bytes must send the next byte to index 0 and not to the next free index. A read cut short by a master NACK and restarted must begin again with the count. The bench bit-bangs both sequences by hand, outside its normal frame tasks, and then reads the whole bank back. The load gate is the other hard case, because its effect depends on byte order within a frame. A byte 8 written while the gate is still open from an earlier frame is copied before byte 9 closes the gate. Write patterns that open and close the gate in successive frames, checked against a per-byte bench model, cover this ordering.

// File: rtl/clkgen_smb_regs.sv
module clkgen_smb_regs #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_BYTES = 10,
  parameter logic [7:0] SIGNATURE = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic       cpu_halt_n,
  input  logic       pci_halt_n,
  input  logic [2:0] fsel,
  input  logic       cur_mult,
  output logic [7:0] cpu_ctrl,
  output logic [7:0] cpu_gate,
  output logic [7:0] pci_en,
  output logic [7:0] aux_en,
  output logic [7:0] mid_en,
  output logic [7:0] misc_ctrl,
  output logic       pci_run,
  output logic [7:0] div_n,
  output logic [6:0] div_r
);
  localparam int         IW       = $clog2(NUM_BYTES) + 1;
  localparam logic [IW-1:0] LAST  = IW'(NUM_BYTES);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_BYTES);
  localparam logic [7:0] M0 = 8'hE8, M1 = 8'h3F, M2 = 8'h7F, M4 = 8'hBF;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD, S_IGN} st_t;

  logic [2:0] scl_sh, sda_sh;
  logic scl_f, sda_f, scl_q, sda_q;
  logic start_c, stop_c, rise, fall, wr_en;
  st_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx, rdval;
  logic [IW-1:0] idx;
  logic rfirst;
  logic [7:0] b0, b1, b2, b3, b4, b5, b7, b8, b9;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1; sda_sh <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_in};
      sda_sh <= {sda_sh[1:0], sda_in};
      if (scl_sh[2] == scl_sh[1]) scl_f <= scl_sh[2];
      sda_f <= sda_sh[2];
      scl_q <= scl_f;
      sda_q <= sda_f;
    end

  assign start_c = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c  = scl_f & scl_q & ~sda_q & sda_f;
  assign rise    = scl_f & ~scl_q;
  assign fall    = ~scl_f & scl_q;
  assign wr_en   = fall && bitcnt == 4'd8 && state == S_WR;
  assign pci_run = pci_halt_n & b0[3];

  always_comb
    case (int'(idx))
      0: rdval = {b0[7:5], cpu_halt_n, pci_run, fsel};
      1: rdval = {cur_mult, 1'b0, b1[5:0]};
      2: rdval = {1'b0, b2[6:0]};
      3: rdval = b3;
      4: rdval = {b4[7], 1'b0, b4[5:0]};
      5: rdval = b5;
      6: rdval = SIGNATURE;
      7: rdval = b7;
      8: rdval = b8;
      9: rdval = b9;
      default: rdval = 8'h00;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; tx <= '0;
      idx <= '0; rfirst <= 1'b0; sda_oe <= 1'b0;
    end else if (start_c) begin
      state <= S_ADDR; bitcnt <= '0; idx <= '0; sda_oe <= 1'b0;
    end else if (stop_c) begin
      state <= S_IDLE; bitcnt <= '0; idx <= '0; sda_oe <= 1'b0;
    end else if (state != S_IDLE) begin
      if (rise) begin
        if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda_f};
        if (bitcnt == 4'd8 && state == S_RD && sda_f) state <= S_IGN;
        bitcnt <= bitcnt + 4'd1;
      end else if (fall) begin
        if (bitcnt == 4'd8) begin
          case (state)
            S_ADDR:
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe <= 1'b1;
                rfirst <= shreg[0];
                state  <= shreg[0] ? S_RD : S_CMD;
              end else state <= S_IGN;
            S_CMD: begin sda_oe <= 1'b1; state <= S_CNT; end
            S_CNT: begin sda_oe <= 1'b1; state <= S_WR; end
            S_WR: begin
              sda_oe <= 1'b1;
              if (idx < LAST) idx <= idx + 1'b1;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          if (state == S_RD) begin
            if (rfirst) begin
              tx <= CNT_BYTE; sda_oe <= ~CNT_BYTE[7]; rfirst <= 1'b0;
            end else begin
              tx <= rdval; sda_oe <= ~rdval[7];
              if (idx < LAST) idx <= idx + 1'b1;
            end
          end else sda_oe <= 1'b0;
        end else if (state == S_RD && bitcnt != 4'd0)
          sda_oe <= ~tx[3'd7 - bitcnt[2:0]];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      b0 <= 8'h08; b1 <= 8'h07; b2 <= 8'h7F; b3 <= 8'hC7; b4 <= 8'h3F;
      b5 <= 8'h40; b7 <= 8'h00; b8 <= 8'h00; b9 <= 8'h00;
    end else if (wr_en)
      case (int'(idx))
        0: b0 <= (b0 & ~M0) | (shreg & M0);
        1: b1 <= (b1 & ~M1) | (shreg & M1);
        2: b2 <= (b2 & ~M2) | (shreg & M2);
        3: b3 <= shreg;
        4: b4 <= (b4 & ~M4) | (shreg & M4);
        5: b5 <= shreg;
        7: b7 <= shreg;
        8: b8 <= shreg;
        9: b9 <= shreg;
        default: ;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_n <= '0; div_r <= '0;
    end else if (b9[0]) begin
      div_n <= b8; div_r <= b9[7:1];
    end

  assign cpu_ctrl  = b0;
  assign cpu_gate  = b1;
  assign pci_en    = b2;
  assign aux_en    = b3;
  assign mid_en    = b4;
  assign misc_ctrl = b5;
endmodule

module clkgen_smb_regs_chk #(parameter int IW = 5) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          scl_q,
  input logic          sda_oe,
  input logic          ign,
  input logic          stop_c,
  input logic [IW-1:0] idx,
  input logic          gate,
  input logic [7:0]    nval,
  input logic [7:0]    div_n,
  input logic [6:0]    div_r,
  input logic          pci_halt_n,
  input logic          pci_run
);
  // R3
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && scl_q) |-> $stable(sda_oe));
  // R1
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> !sda_oe);
  // R8
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> ($stable(div_n) && $stable(div_r)));
  // R8
  gate_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> (div_n == $past(nval)));
  // R5
  pci_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_halt_n |-> !pci_run);
  // R10
  stop_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (idx == '0));
endmodule

bind clkgen_smb_regs clkgen_smb_regs_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_q(scl_q), .sda_oe(sda_oe),
  .ign(state == S_IGN), .stop_c(stop_c), .idx(idx), .gate(b9[0]),
  .nval(b8), .div_n(div_n), .div_r(div_r), .pci_halt_n(pci_halt_n),
  .pci_run(pci_run));

// File: tb/clkgen_smb_regs_bench.sv
module clkgen_smb_regs_bench;
  localparam int H = 12;
  logic clk = 0, rst_n = 0;
  logic scl = 1, m_low = 0;
  logic cpu_p = 1, pci_p = 1, mult_p = 1;
  logic [2:0] fsel_p = 3'b101;
  wire sda_w;
  logic sda_oe, pci_run;
  logic [7:0] cpu_ctrl, cpu_gate, pci_en, aux_en, mid_en, misc_ctrl, div_n;
  logic [6:0] div_r;
  int nt = 0, nf = 0;
  logic [7:0] st [10];
  logic [7:0] wm [10];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic [7:0] dn;
  logic [6:0] dr;

  always #5 clk = ~clk;
  assign sda_w = ~(m_low | sda_oe);

  clkgen_smb_regs u_clkgen_smb_regs (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_w), .sda_oe(sda_oe),
    .cpu_halt_n(cpu_p), .pci_halt_n(pci_p), .fsel(fsel_p), .cur_mult(mult_p),
    .cpu_ctrl(cpu_ctrl), .cpu_gate(cpu_gate), .pci_en(pci_en), .aux_en(aux_en),
    .mid_en(mid_en), .misc_ctrl(misc_ctrl), .pci_run(pci_run),
    .div_n(div_n), .div_r(div_r));

  task automatic waitc(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nt++;
    if (act !== exp) begin
      nf++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic m_start; m_low = 0; waitc(H); scl = 1; waitc(H); m_low = 1; waitc(H); scl = 0; waitc(2); endtask
  task automatic m_stop; m_low = 1; waitc(H); scl = 1; waitc(H); m_low = 0; waitc(H); endtask
  task automatic bit_out(input logic b); m_low = ~b; waitc(H); scl = 1; waitc(H); scl = 0; waitc(2); endtask
  task automatic bit_in(output logic b);
    m_low = 0; waitc(H); scl = 1; waitc(H/2); b = sda_w; waitc(H - H/2); scl = 0; waitc(2);
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(r); ack = ~r;
  endtask
  task automatic recv_byte(input logic last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(last);
    m_low = 0;
  endtask

  task automatic mupd(input int i, input logic [7:0] v);
    if (i < 10) st[i] = (st[i] & ~wm[i]) | (v & wm[i]);
    if (st[9][0]) begin dn = st[8]; dr = st[9][7:1]; end
  endtask

  function automatic logic [7:0] exp_rd(input int i);
    if (i == 0) return {st[0][7:5], cpu_p, pci_p & st[0][3], fsel_p};
    if (i == 1) return {mult_p, 1'b0, st[1][5:0]};
    if (i < 10) return st[i];
    return 8'h00;
  endfunction

  task automatic wr_frame(input logic [7:0] addr, input logic [7:0] cmd, input int n,
                          output logic aack, output logic dack);
    logic a;
    m_start;
    send_byte(addr, aack);
    send_byte(cmd, a); dack = a;
    send_byte(8'(n), a); dack &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], a); dack &= a;
      if (addr == 8'hD2) mupd(i, wbuf[i]);
    end
    m_stop; waitc(4);
  endtask

  task automatic rd_frame(input int n, output logic aack);
    m_start;
    send_byte(8'hD3, aack);
    for (int i = 0; i <= n; i++) recv_byte(i == n, rbuf[i]);
    m_stop; waitc(4);
  endtask

  task automatic verify_all(input string t);
    logic a;
    rd_frame(12, a);
    chk({t, " R1 read address ack"}, {7'd0, a}, 8'h01);
    chk({t, " R9 count"}, rbuf[0], 8'd10);
    for (int i = 0; i < 12; i++)
      chk(i == 0 ? {t, " R4 byte0"} : i == 6 ? {t, " R6 signature"} :
          i >= 10 ? {t, " R9 past end"} : (i == 1 || i == 2 || i == 4) ? {t, " R11 byte"} :
          {t, " R3 byte"}, rbuf[i+1], exp_rd(i));
    chk({t, " R3 cpu_ctrl"}, cpu_ctrl, st[0]);
    chk({t, " R3 cpu_gate"}, cpu_gate, st[1]);
    chk({t, " R3 pci_en"}, pci_en, st[2]);
    chk({t, " R3 aux_en"}, aux_en, st[3]);
    chk({t, " R3 mid_en"}, mid_en, st[4]);
    chk({t, " R3 misc_ctrl"}, misc_ctrl, st[5]);
    chk({t, " R5 pci_run"}, {7'd0, pci_run}, {7'd0, pci_p & st[0][3]});
    chk({t, " R8 div_n"}, div_n, dn);
    chk({t, " R8 div_r"}, {1'b0, div_r}, {1'b0, dr});
  endtask

  task automatic summary; $display("  [TB] %0d tests run, %0d failed", nt, nf); endtask

  initial begin
    repeat (190000) @(posedge clk);
    nt++; nf++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary;
    $finish;
  end

  initial begin
    logic aa, da;
    st = '{8'h08, 8'h07, 8'h7F, 8'hC7, 8'h3F, 8'h40, 8'h03, 8'h00, 8'h00, 8'h00};
    wm = '{8'hE8, 8'h3F, 8'h7F, 8'hFF, 8'hBF, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF};
    dn = 0; dr = 0;
    waitc(3); rst_n = 1; waitc(5);
    chk("R7 reset sda_oe", {7'd0, sda_oe}, 8'h00);
    chk("R7 reset pci_en", pci_en, 8'h7F);
    chk("R7 reset aux_en", aux_en, 8'hC7);
    chk("R7 reset cpu_gate", cpu_gate, 8'h07);
    chk("R7 reset mid_en", mid_en, 8'h3F);
    chk("R7 reset div_n", div_n, 8'h00);
    verify_all("R7 reset");

    for (int v = 0; v < 64; v++) begin
      {mult_p, cpu_p, pci_p, fsel_p} = 6'(v);
      waitc(4);
      rd_frame(2, aa);
      chk("R4 pin sweep byte0", rbuf[1], exp_rd(0));
      chk("R4 pin sweep byte1", rbuf[2], exp_rd(1));
      chk("R5 pin sweep pci_run", {7'd0, pci_run}, {7'd0, pci_p & st[0][3]});
    end
    {mult_p, cpu_p, pci_p, fsel_p} = 6'b110110;

    for (int p = 0; p < 5; p++) begin
      for (int i = 0; i < 12; i++)
        case (p)
          0: wbuf[i] = 8'hFF;
          1: wbuf[i] = 8'h00;
          2: wbuf[i] = 8'hA5 ^ 8'(i * 37);
          3: wbuf[i] = 8'(i * 29 + 51);
          default: wbuf[i] = 8'h5A ^ 8'(i * 17);
        endcase
      wr_frame(8'hD2, 8'(p * 85), 12, aa, da);
      chk("R1 write address ack", {7'd0, aa}, 8'h01);
      chk("R2 command count and data acks", {7'd0, da}, 8'h01);
      verify_all("pattern");
      if (p == 1) begin
        pci_p = 1; waitc(3);
        chk("R5 stored bit clear halts pci", {7'd0, pci_run}, 8'h00);
      end
    end

    for (int i = 0; i < 12; i++) wbuf[i] = 8'h11;
    wr_frame(8'hA4, 8'h00, 12, aa, da);
    chk("R1 foreign address nack", {7'd0, aa}, 8'h00);
    chk("R1 foreign data nack", {7'd0, da}, 8'h00);
    wr_frame(8'hD0, 8'h00, 4, aa, da);
    chk("R1 near address nack", {7'd0, aa}, 8'h00);
    m_start; send_byte(8'hD5, aa); m_stop; waitc(4);
    chk("R1 foreign read nack", {7'd0, aa}, 8'h00);
    verify_all("R1 after foreign");

    for (int i = 0; i < 10; i++) wbuf[i] = st[i];
    wbuf[8] = 8'h3C; wbuf[9] = 8'h00;
    wr_frame(8'hD2, 8'h00, 10, aa, da);
    verify_all("R8 gate close");
    wbuf[8] = 8'h77; wbuf[9] = 8'h00;
    wr_frame(8'hD2, 8'h00, 10, aa, da);
    chk("R8 closed gate holds", div_n, 8'h3C);
    verify_all("R8 gate closed");
    wbuf[9] = 8'h91;
    wr_frame(8'hD2, 8'h00, 10, aa, da);
    chk("R8 open gate loads n", div_n, 8'h77);
    chk("R8 open gate loads r", {1'b0, div_r}, 8'h48);
    verify_all("R8 gate open");

    m_start;
    send_byte(8'hD2, aa); send_byte(8'h00, aa); send_byte(8'h02, aa);
    send_byte(8'h20, aa); mupd(0, 8'h20);
    send_byte(8'h15, aa); mupd(1, 8'h15);
    m_start;
    send_byte(8'hD2, aa); send_byte(8'hFF, aa); send_byte(8'h01, aa);
    send_byte(8'hC8, aa); mupd(0, 8'hC8);
    m_stop; waitc(4);
    chk("R10 restart write lands byte0", cpu_ctrl, st[0]);
    chk("R10 restart leaves byte1", cpu_gate, st[1]);
    m_start;
    send_byte(8'hD3, aa);
    recv_byte(1'b0, rbuf[0]); recv_byte(1'b1, rbuf[1]);
    m_start;
    send_byte(8'hD3, aa);
    recv_byte(1'b0, rbuf[2]); recv_byte(1'b1, rbuf[3]);
    m_stop; waitc(4);
    chk("R10 restart read count", rbuf[2], 8'd10);
    chk("R10 restart read byte0", rbuf[3], exp_rd(0));
    chk("R9 nack released line", {7'd0, sda_oe}, 8'h00);
    verify_all("R10 final");

    summary;
    $finish;
  end
endmodule